// File: doc/BRIEF.md
# Multi-Width Serial Flash Command Front End

This block is the device-facing half of a serial flash port. A host drives a chip select, a serial clock and up to four data lines; the block recognises an 8-bit command and gathers a 24-bit start address. For the supported read commands it fetches bytes through a one-request, one-byte parallel port and returns them on two or four lines. Reads continue from consecutive addresses until the host deselects. The flash array, program and erase timing, and pad circuitry all sit outside the block.

All serial inputs are oversampled on a faster system clock through synchronizer stages, and clock edges are found by comparing successive synchronized samples. Because of this, a host that parks the serial clock low between commands and a host that parks it high are served the same way, with no mode setting. A sticky quad flag, set by a command, widens every later command to all four lines. The two upper lines then carry data instead of acting as write-protect and spare pins.

Top module: `sflash_frontend`

## Requirements
- R1: Both idle levels of the serial clock (low or high while deselected) are accepted, with no configuration input.
- R2: Command, address and input bits are captured on rising serial-clock edges only. The address is 24 bits, most significant group first.
- R3: Output groups change only on falling serial-clock edges. The first group of a read is launched on the first falling edge after the last dummy clock.
- R4: When chip select is high, all four output enables are 0 and any partly received command is dropped. The next selection starts a fresh command.
- R5: From reset until chip select has been seen high, no command is accepted: no read request is made and no line is driven.
- R6: Command 3Bh takes its address on line 0 alone, then 8 dummy clocks, and returns data on lines 1:0 (output enable 4'b0011).
- R7: Command BBh takes its address on lines 1:0, then 4 dummy clocks, and returns data on lines 1:0.
- R8: Command EBh takes its address on lines 3:0, then 4 dummy clocks, and returns data on lines 3:0 (output enable 4'b1111).
- R9: Command 38h sets the quad flag (output `quad_mode`), which stays set until reset. While it is set, the command, address and data of every read use lines 3:0, and dummy counts stay as in R6 to R8.
- R10: `rd_req` is a one-cycle pulse with `rd_addr`; `rd_data` is valid on the following clock. After each byte the address advances by one and wraps from FFFFFFh to 000000h.
- R11: An unrecognised command makes the block ignore all clocks until chip select rises. It makes no request, drives no line and leaves the quad flag unchanged.
- R12: Within a group, the lowest-numbered line holds the lowest-order bit. Groups of a byte go most significant first, so with four lines the first group is bits 7:4 on lines 3:0.
- R13: No line is driven during the dummy clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_io_in | input | 4 | Levels seen on the four data lines |
| spi_io_out | output | 4 | Values to drive onto the data lines |
| spi_io_oe | output | 4 | Per-line output enable |
| rd_req | output | 1 | Byte fetch request pulse |
| rd_addr | output | 24 | Byte address of the fetch |
| rd_data | input | 8 | Fetched byte, valid the clock after `rd_req` |
| quad_mode | output | 1 | Sticky quad flag |

## Verification
Several rules are checked on every clock: outputs change only after a falling edge, addresses change only after a rising edge or a byte advance, enables clear on deselect and take only the legal shapes, drive never starts outside the data phase, and the quad flag is sticky. The bench scenarios cover what needs a whole transaction: correct line widths and dummy counts per command, both clock idle levels, lane order, address wrap, abort recovery, the unarmed state after reset, and silence after an unknown command.

// File: rtl/sflash_fe_pkg.sv
package sflash_fe_pkg;

  localparam logic [7:0] OP_DUAL_OUT = 8'h3B;
  localparam logic [7:0] OP_DUAL_IO  = 8'hBB;
  localparam logic [7:0] OP_QUAD_IO  = 8'hEB;
  localparam logic [7:0] OP_QUAD_ON  = 8'h38;

  typedef enum logic [2:0] {
    ST_SKIP, ST_OPC, ST_ADDR, ST_DUMMY, ST_DATA
  } fe_state_t;

  typedef struct packed {
    logic       valid;
    logic       set_quad;
    logic       long_dummy;
    logic [2:0] aw;
    logic [2:0] dw;
  } fe_cmd_t;

  // Command table: line widths for the address and data phases
  function automatic fe_cmd_t decode_op(input logic [7:0] op, input logic quad);
    fe_cmd_t c;
    c = '0;
    c.aw = 3'd1;
    c.dw = 3'd2;
    case (op)
      OP_QUAD_ON: begin c.valid = 1'b1; c.set_quad = 1'b1; end
      OP_DUAL_OUT: begin
        c.valid = 1'b1; c.long_dummy = 1'b1;
        c.aw = quad ? 3'd4 : 3'd1;
        c.dw = quad ? 3'd4 : 3'd2;
      end
      OP_DUAL_IO: begin
        c.valid = 1'b1;
        c.aw = quad ? 3'd4 : 3'd2;
        c.dw = quad ? 3'd4 : 3'd2;
      end
      OP_QUAD_IO: begin c.valid = 1'b1; c.aw = 3'd4; c.dw = 3'd4; end
      default: c.valid = 1'b0;
    endcase
    return c;
  endfunction

  function automatic logic [3:0] lane_mask(input logic [2:0] w);
    case (w)
      3'd4:    return 4'hF;
      3'd2:    return 4'h3;
      default: return 4'h2;
    endcase
  endfunction

  // Top group of a byte placed on the lines, low line = low bit
  function automatic logic [3:0] place_group(input logic [7:0] b, input logic [2:0] w);
    case (w)
      3'd4:    return b[7:4];
      3'd2:    return {2'b00, b[7:6]};
      default: return {2'b00, b[7], 1'b0};
    endcase
  endfunction

  function automatic logic [2:0] groups_m1(input logic [2:0] w);
    case (w)
      3'd4:    return 3'd1;
      3'd2:    return 3'd3;
      default: return 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/fe_sync.sv
module fe_sync #(
  parameter int W = 6,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] r;
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) r <= RST_VAL;
        else        r <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) r <= RST_VAL;
        else        r <= g_stage[s-1].r;
    end
  end

  assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/fe_cmd_fsm.sv
module fe_cmd_fsm
  import sflash_fe_pkg::*;
#(
  parameter int ADDR_BITS   = 24,
  parameter int DUMMY_LONG  = 8,
  parameter int DUMMY_SHORT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_s,
  input  logic                 sck_rise,
  input  logic [3:0]           io_s,
  input  logic                 next_byte,
  output logic                 rd_req,
  output logic [ADDR_BITS-1:0] rd_addr,
  output logic                 quad_mode,
  output logic                 data_active,
  output logic [2:0]           data_w,
  output logic                 armed
);

  localparam int CW  = $clog2(ADDR_BITS + 5);
  localparam int DCW = $clog2(DUMMY_LONG + 1);

  fe_state_t             state_q;
  logic [CW-1:0]         cnt_q, cnt_nx;
  logic [ADDR_BITS-1:0]  sh_q, sh_nx, addr_q;
  logic [2:0]            aw_q, dw_q, in_w;
  logic [DCW-1:0]        dcnt_q;
  logic                  quad_q, armed_q, req_q;
  fe_cmd_t               cmd;

  function automatic logic [ADDR_BITS-1:0] shift_in(
    input logic [ADDR_BITS-1:0] s, input logic [3:0] io, input logic [2:0] w);
    case (w)
      3'd4:    return {s[ADDR_BITS-5:0], io};
      3'd2:    return {s[ADDR_BITS-3:0], io[1:0]};
      default: return {s[ADDR_BITS-2:0], io[0]};
    endcase
  endfunction

  assign in_w   = (state_q == ST_OPC) ? (quad_q ? 3'd4 : 3'd1) : aw_q;
  assign sh_nx  = shift_in(sh_q, io_s, in_w);
  assign cnt_nx = cnt_q + CW'(in_w);
  assign cmd    = decode_op(sh_nx[7:0], quad_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SKIP;
      cnt_q   <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      aw_q    <= 3'd1;
      dw_q    <= 3'd2;
      dcnt_q  <= '0;
      quad_q  <= 1'b0;
      armed_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (cs_s) begin
        armed_q <= 1'b1;
        state_q <= ST_OPC;
        cnt_q   <= '0;
      end else begin
        case (state_q)
          ST_OPC: if (sck_rise) begin
            sh_q <= sh_nx;
            if (cnt_nx == CW'(8)) begin
              cnt_q <= '0;
              if (cmd.valid && cmd.set_quad) begin
                quad_q  <= 1'b1;
                state_q <= ST_SKIP;
              end else if (cmd.valid) begin
                aw_q    <= cmd.aw;
                dw_q    <= cmd.dw;
                dcnt_q  <= cmd.long_dummy ? DCW'(DUMMY_LONG) : DCW'(DUMMY_SHORT);
                state_q <= ST_ADDR;
              end else begin
                state_q <= ST_SKIP;
              end
            end else begin
              cnt_q <= cnt_nx;
            end
          end
          ST_ADDR: if (sck_rise) begin
            sh_q <= sh_nx;
            if (cnt_nx == CW'(ADDR_BITS)) begin
              addr_q  <= sh_nx;
              req_q   <= 1'b1;
              state_q <= ST_DUMMY;
            end else begin
              cnt_q <= cnt_nx;
            end
          end
          ST_DUMMY: if (sck_rise) begin
            dcnt_q <= dcnt_q - 1'b1;
            if (dcnt_q == DCW'(1)) state_q <= ST_DATA;
          end
          ST_DATA: if (next_byte) begin
            addr_q <= addr_q + 1'b1;
            req_q  <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_req      = req_q;
  assign rd_addr     = addr_q;
  assign quad_mode   = quad_q;
  assign data_active = (state_q == ST_DATA) && !cs_s;
  assign data_w      = dw_q;
  assign armed       = armed_q;

  // R2: the address only moves after a rising edge or a byte advance
  p_addr_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_addr) |-> $past(sck_rise || next_byte));
  // R10: fetch requests are single-cycle pulses
  p_req_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  // R9: quad flag never clears once set
  p_quad_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    quad_mode |=> quad_mode);
  // R5: no fetch before the first deselect
  p_quiet_unarmed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !rd_req);

endmodule

// File: rtl/fe_out_shifter.sv
module fe_out_shifter
  import sflash_fe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_s,
  input  logic       active,
  input  logic       sck_fall,
  input  logic [2:0] dw,
  input  logic       rd_req,
  input  logic [7:0] rd_data,
  output logic [3:0] io_out,
  output logic [3:0] io_oe,
  output logic       next_byte
);

  logic [7:0] pre_q, sh_q, sh_nx;
  logic [2:0] gcnt_q;
  logic [3:0] out_q, oe_q;
  logic       req_d;
  logic       launch;

  assign launch    = active && sck_fall;
  assign next_byte = launch && (gcnt_q == 3'd0);
  assign sh_nx     = (gcnt_q == 3'd0) ? pre_q : (sh_q << dw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      sh_q   <= '0;
      gcnt_q <= '0;
      out_q  <= '0;
      oe_q   <= '0;
      req_d  <= 1'b0;
    end else begin
      req_d <= rd_req;
      if (req_d) pre_q <= rd_data;
      if (cs_s) begin
        oe_q   <= '0;
        gcnt_q <= '0;
      end else if (launch) begin
        oe_q   <= lane_mask(dw);
        sh_q   <= sh_nx;
        out_q  <= place_group(sh_nx, dw);
        gcnt_q <= (gcnt_q == 3'd0) ? groups_m1(dw) : gcnt_q - 1'b1;
      end
    end
  end

  assign io_out = out_q;
  assign io_oe  = oe_q;

  // R4: deselect releases every line
  p_oe_desel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (io_oe == 4'h0));
  // R3: output groups move only after a falling edge
  p_launch_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(io_out) |-> $past(sck_fall));
  // R12: only the legal enable shapes appear
  p_oe_shape_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'h0) || (io_oe == 4'h3) || (io_oe == 4'hF) || (io_oe == 4'h2));

endmodule

// File: rtl/sflash_frontend.sv
module sflash_frontend
  import sflash_fe_pkg::*;
#(
  parameter int ADDR_BITS   = 24,
  parameter int SYNC_STAGES = 2,
  parameter int DUMMY_LONG  = 8,
  parameter int DUMMY_SHORT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 spi_sck,
  input  logic                 spi_cs_n,
  input  logic [3:0]           spi_io_in,
  output logic [3:0]           spi_io_out,
  output logic [3:0]           spi_io_oe,
  output logic                 rd_req,
  output logic [ADDR_BITS-1:0] rd_addr,
  input  logic [7:0]           rd_data,
  output logic                 quad_mode
);

  localparam int SW = 6;

  logic [SW-1:0] sync_q;
  logic          cs_s, sck_s, sck_prev;
  logic [3:0]    io_s;
  logic          sck_rise, sck_fall;
  logic          next_byte, data_active, armed;
  logic [2:0]    data_w;

  // chip select syncs to 0: the block starts selected but unarmed
  fe_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_cs_n, spi_sck, spi_io_in}), .q(sync_q));

  assign cs_s  = sync_q[5];
  assign sck_s = sync_q[4];
  assign io_s  = sync_q[3:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= sck_s;

  assign sck_rise = sck_s && !sck_prev;
  assign sck_fall = !sck_s && sck_prev;

  fe_cmd_fsm #(.ADDR_BITS(ADDR_BITS), .DUMMY_LONG(DUMMY_LONG),
               .DUMMY_SHORT(DUMMY_SHORT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sck_rise(sck_rise),
    .io_s(io_s), .next_byte(next_byte), .rd_req(rd_req),
    .rd_addr(rd_addr), .quad_mode(quad_mode), .data_active(data_active),
    .data_w(data_w), .armed(armed));

  fe_out_shifter u_out (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .active(data_active),
    .sck_fall(sck_fall), .dw(data_w), .rd_req(rd_req), .rd_data(rd_data),
    .io_out(spi_io_out), .io_oe(spi_io_oe), .next_byte(next_byte));

  // R13: driving starts only on a falling edge inside the data phase
  p_oe_start_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|spi_io_oe) |-> $past(data_active && sck_fall));
  // R5: nothing is driven before the first deselect
  p_unarmed_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (spi_io_oe == 4'h0));

endmodule

// File: tb/sflash_frontend_bench.sv
module sflash_frontend_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sck = 1'b0;
  logic        spi_cs_n = 1'b0;
  logic [3:0]  spi_io_in = 4'h0;
  logic [3:0]  spi_io_out, spi_io_oe;
  logic        rd_req;
  logic [23:0] rd_addr;
  logic [7:0]  rd_data;
  logic        quad_mode;

  int n_checks = 0;
  int n_fails = 0;
  int req_count = 0;
  int oe_cycles = 0;
  bit quad_exp = 1'b0;
  bit done = 1'b0;
  string cur_tag = "";
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sflash_frontend u_sflash_frontend (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_io_in(spi_io_in), .spi_io_out(spi_io_out), .spi_io_oe(spi_io_oe),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .quad_mode(quad_mode));

  function automatic logic [7:0] mem_f(input logic [23:0] a);
    return (a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]}) + 8'h5B;
  endfunction

  // stand-in array with one-cycle read latency
  always_ff @(posedge clk) if (rd_req) rd_data <= mem_f(rd_addr);
  always @(posedge clk) if (rst_n && rd_req) req_count++;
  always @(negedge clk) if (rst_n && spi_io_oe != 4'h0) oe_cycles++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  task automatic tick_half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic put_group(input logic [3:0] g);
    spi_sck = 1'b0; spi_io_in = g; tick_half();
    spi_sck = 1'b1; tick_half();
  endtask

  task automatic put_word(input logic [31:0] v, input int nbits, input int w);
    for (int i = nbits - w; i >= 0; i -= w)
      put_group(4'((v >> i) & ((32'd1 << w) - 1)));
  endtask

  task automatic start_tx(input bit mode3);
    spi_sck = mode3; tick_half();
    spi_cs_n = 1'b0; tick_half();
  endtask

  task automatic end_tx(input bit mode3, input string tag);
    spi_sck = mode3; tick_half();
    spi_cs_n = 1'b1; tick_half(); tick_half();
    check(spi_io_oe == 4'h0, {tag, " R4 release on deselect"}, spi_io_oe, 0);
  endtask

  // driver: issues a read and pushes the expected bytes to the scoreboard
  task automatic do_read(input logic [7:0] op, input logic [23:0] addr,
                         input int n, input bit mode3, input string tag);
    int opw, aw, dw, dummy;
    logic [3:0] oe_exp;
    logic [7:0] b;
    opw = quad_exp ? 4 : 1;
    aw = quad_exp ? 4 : (op == 8'h3B ? 1 : (op == 8'hBB ? 2 : 4));
    dw = (quad_exp || op == 8'hEB) ? 4 : 2;
    dummy = (op == 8'h3B) ? 8 : 4;
    oe_exp = (dw == 4) ? 4'hF : 4'h3;
    cur_tag = tag;
    start_tx(mode3);
    put_word({24'h0, op}, 8, opw);
    put_word({8'h0, addr}, 24, aw);
    for (int d = 0; d < dummy; d++) begin
      put_group(4'h0);
      check(spi_io_oe == 4'h0, {tag, " R13 dummy undriven"}, spi_io_oe, 0);
    end
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(mem_f(addr + 24'(k)));
      b = '0;
      for (int g = 0; g < 8 / dw; g++) begin
        spi_sck = 1'b0; tick_half();
        if (g == 0)
          check(spi_io_oe == oe_exp, {tag, " R3 R12 enable shape"}, spi_io_oe, oe_exp);
        b = 8'((b << dw) | (spi_io_out & ((4'd1 << dw) - 4'd1)));
        spi_sck = 1'b1; tick_half();
      end
      got_q.push_back(b);
    end
    end_tx(mode3, tag);
  endtask

  // monitor: pops and compares as bytes arrive
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] g, e;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        check(g == e, {cur_tag, " read byte"}, g, e);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int rq0, oe0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(spi_io_oe == 4'h0, "R5 reset enables", spi_io_oe, 0);
    check(rd_req == 1'b0, "R5 reset request", rd_req, 0);
    check(quad_mode == 1'b0, "R9 reset quad flag", quad_mode, 0);

    // R5: chip select low since reset, full command must be ignored
    put_word(32'hEB, 8, 1);
    put_word(32'h000040, 24, 1);
    for (int i = 0; i < 12; i++) put_group(4'h0);
    check(req_count == 0, "R5 unarmed no request", req_count, 0);
    check(oe_cycles == 0, "R5 unarmed no drive", oe_cycles, 0);
    spi_sck = 1'b0; tick_half();
    spi_cs_n = 1'b1; tick_half();

    do_read(8'h3B, 24'h001234, 3, 1'b0, "R6 R1 R2 mode0");
    do_read(8'hBB, 24'h00ABCD, 3, 1'b1, "R7 R1 mode3");
    do_read(8'hEB, 24'hFFFFFE, 4, 1'b0, "R8 R10 R12 wrap");

    // R4: partial command then deselect
    start_tx(1'b0);
    put_word(32'hE, 4, 1);
    end_tx(1'b0, "R4 abort");
    do_read(8'hEB, 24'h000100, 2, 1'b1, "R4 after abort");

    // R11: unknown command
    rq0 = req_count; oe0 = oe_cycles;
    start_tx(1'b0);
    put_word(32'h9F, 8, 1);
    for (int i = 0; i < 40; i++) put_group(4'hF);
    check(req_count == rq0, "R11 no request", req_count, rq0);
    check(oe_cycles == oe0, "R11 no drive", oe_cycles, oe0);
    end_tx(1'b0, "R11");
    check(quad_mode == 1'b0, "R11 quad unchanged", quad_mode, 0);

    // R9: enable quad, then reads run on four lines
    start_tx(1'b0);
    put_word(32'h38, 8, 1);
    end_tx(1'b0, "R9 enable");
    quad_exp = 1'b1;
    check(quad_mode == 1'b1, "R9 quad set", quad_mode, 1);
    do_read(8'h3B, 24'h0A0B0C, 3, 1'b0, "R9 quad 3B");
    do_read(8'hEB, 24'h123456, 2, 1'b1, "R9 quad EB mode3");
    check(quad_mode == 1'b1, "R9 quad sticky", quad_mode, 1);

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule